// File: doc/BRIEF.md
# Timer Compare Event Unit

This block gives one processor core a free-running system counter and a compare target that software moves forward by adding an offset to its current value. Because the new target is always the old one plus an offset, a periodic event keeps its phase no matter how late the software gets round to rearming. When the counter reaches the target, a sticky event flag is raised and stays up until a consumer takes it.

Two consumer operations exist: a poll and a jump-style test. Each operation is two clocks long. Both copy the flag into a carry bit and clear it. Both do this on the first of the two clocks, so the sample and the clear always fall in the same clock. When a new match lands in the clock where the flag is being consumed, the new event wins. The consumer reads 0, and the flag stays set for the next consumer. No event can vanish and leave a waiting loop spinning until the counter wraps round.

Top module: `timer_event_unit`

## Requirements
- R1: While rst_n is low, counter, target, event_flag and carry_out are all 0.
- R2: The counter rises by exactly 1 on every clock after reset and wraps from all ones to 0 (modulo 2^CNT_W, CNT_W = 32 by default).
- R3: A clock with add_en high makes target equal to the old target plus add_val, modulo 2^CNT_W. With add_en low, the target keeps its value.
- R4: When counter equals target before a clock edge, event_flag is 1 after that edge. Once set, the flag stays 1 until it is consumed.
- R5: A clock with poll_req high loads carry_out with the event_flag value from before that edge. The same edge clears the flag unless a new match occurs in that clock. A poll of a clear flag returns 0 straight away.
- R6: A clock with jtest_req high samples and clears the flag exactly as a poll does.
- R7: When a match and a consume request fall in the same clock, carry_out reads 0 and event_flag is 1 afterwards. The next consume returns 1.
- R8: carry_out holds its value on every clock without poll_req or jtest_req.
- R9: A target set 19+k clocks ahead (k = 0..7) while a poll repeats every two clocks is reported by exactly one poll, well before any counter wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| add_en | input | 1 | Add add_val to the target on this clock |
| add_val | input | CNT_W | Offset added to the target (modulo 2^CNT_W) |
| poll_req | input | 1 | First clock of a poll operation |
| jtest_req | input | 1 | First clock of a jump-on-event test |
| carry_out | output | 1 | Sampled event flag from the last consume |
| event_flag | output | 1 | Sticky compare event flag |
| counter | output | CNT_W | Free-running system counter |
| target | output | CNT_W | Compare target |

## Verification
The first stimulus is directed: a lone match, then an empty poll, then a consume placed exactly in the clock of a match. Together these separate a design that samples and clears on the first clock from one that loses or doubles the event. A sweep over eight phase offsets between the event and a two-clock poll loop shows that each match is reported exactly once, whatever the phase. A long random run mixes polls, jump tests and target rearms, some of them in the same clock as a match. Against a bench model, this run catches errors in carry hold, in clear priority and in the target arithmetic. A narrow instance shows the counter wrapping.

// File: rtl/tev_pkg.sv
package tev_pkg;
  parameter int unsigned TEV_DEF_W = 32;

  typedef struct packed {
    logic poll;
    logic jtest;
  } tev_req_t;

  function automatic logic tev_consumes(tev_req_t r);
    return r.poll | r.jtest;
  endfunction
endpackage

// File: rtl/tev_counter.sv
module tev_counter #(
  parameter int unsigned W = tev_pkg::TEV_DEF_W
) (
  input  logic         clk,
  input  logic         rst_n,
  output logic [W-1:0] cnt_q
);
  logic [W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R2
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> cnt_q == $past(cnt_q) + W'(1));
endmodule

// File: rtl/tev_target.sv
module tev_target #(
  parameter int unsigned W = tev_pkg::TEV_DEF_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         add_en,
  input  logic [W-1:0] add_val,
  output logic [W-1:0] tgt_q
);
  logic [W-1:0] tgt_d;

  always_comb begin
    tgt_d = tgt_q;
    if (add_en) tgt_d = tgt_q + add_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tgt_q <= '0;
    else        tgt_q <= tgt_d;
  end

  // R3
  tgt_add_chk: assert property (@(posedge clk) disable iff (!rst_n)
    add_en |=> tgt_q == $past(tgt_q) + $past(add_val));
  // R3
  tgt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !add_en |=> $stable(tgt_q));
endmodule

// File: rtl/tev_flag.sv
module tev_flag #(
  parameter int unsigned W = tev_pkg::TEV_DEF_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [W-1:0]       cnt,
  input  logic [W-1:0]       tgt,
  input  tev_pkg::tev_req_t  req,
  output logic               flag_q,
  output logic               carry_q
);
  logic hit;
  logic take;
  logic flag_d;
  logic carry_d;

  always_comb begin
    hit  = (cnt == tgt);
    take = tev_pkg::tev_consumes(req);
    // sample and clear share one clock; a fresh hit overrides the clear
    flag_d  = hit | (flag_q & ~take);
    carry_d = carry_q;
    if (take) carry_d = flag_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q  <= 1'b0;
      carry_q <= 1'b0;
    end else begin
      flag_q  <= flag_d;
      carry_q <= carry_d;
    end
  end

  // R4
  flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> flag_q);
  // R4
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flag_q && !take |=> flag_q);
  // R5
  carry_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> carry_q == $past(flag_q));
  // R5
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take && !hit |=> !flag_q);
  // R7
  same_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take && hit && !flag_q |=> flag_q && !carry_q);
  // R8
  carry_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> $stable(carry_q));
endmodule

// File: rtl/timer_event_unit.sv
module timer_event_unit #(
  parameter int unsigned CNT_W = tev_pkg::TEV_DEF_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             add_en,
  input  logic [CNT_W-1:0] add_val,
  input  logic             poll_req,
  input  logic             jtest_req,
  output logic             carry_out,
  output logic             event_flag,
  output logic [CNT_W-1:0] counter,
  output logic [CNT_W-1:0] target
);
  tev_pkg::tev_req_t req;

  always_comb begin
    req.poll  = poll_req;
    req.jtest = jtest_req;
  end

  tev_counter #(.W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .cnt_q (counter)
  );

  tev_target #(.W(CNT_W)) u_tgt (
    .clk     (clk),
    .rst_n   (rst_n),
    .add_en  (add_en),
    .add_val (add_val),
    .tgt_q   (target)
  );

  tev_flag #(.W(CNT_W)) u_flag (
    .clk     (clk),
    .rst_n   (rst_n),
    .cnt     (counter),
    .tgt     (target),
    .req     (req),
    .flag_q  (event_flag),
    .carry_q (carry_out)
  );

  // R1
  always_comb begin
    if (!rst_n) begin
      rst_state_chk: assert (counter == '0 && target == '0 && !event_flag && !carry_out);
    end
  end
endmodule

// File: tb/timer_event_unit_tb.sv
module timer_event_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        add_en, poll_req, jtest_req;
  logic [31:0] add_val;
  logic        carry_out, event_flag;
  logic [31:0] counter, target;
  logic        n_carry, n_flag;
  logic [7:0]  n_counter, n_target;

  logic [31:0] m_cnt, m_tgt;
  logic        m_flag, m_carry;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  timer_event_unit u_dut (
    .clk(clk), .rst_n(rst_n), .add_en(add_en), .add_val(add_val),
    .poll_req(poll_req), .jtest_req(jtest_req), .carry_out(carry_out),
    .event_flag(event_flag), .counter(counter), .target(target));

  timer_event_unit #(.CNT_W(8)) u_dut_narrow (
    .clk(clk), .rst_n(rst_n), .add_en(1'b0), .add_val(8'h00),
    .poll_req(1'b0), .jtest_req(1'b0), .carry_out(n_carry),
    .event_flag(n_flag), .counter(n_counter), .target(n_target));

  // reference model written from the requirements
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt <= 0; m_tgt <= 0; m_flag <= 0; m_carry <= 0;
    end else begin
      m_cnt  <= m_cnt + 1;
      if (add_en) m_tgt <= m_tgt + add_val;
      m_flag <= (m_cnt == m_tgt) || (m_flag && !(poll_req || jtest_req));
      if (poll_req || jtest_req) m_carry <= m_flag;
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
    chk("R2 counter", counter, m_cnt);
    chk("R3 target", target, m_tgt);
    chk("R4 flag", {31'b0, event_flag}, {31'b0, m_flag});
    chk("R5 carry", {31'b0, carry_out}, {31'b0, m_carry});
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] c;
    logic        prev_flag;
    int          hits;
    void'($urandom(32'd1234));
    rst_n = 0; add_en = 0; add_val = 0; poll_req = 0; jtest_req = 0;
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    chk("R1 counter", counter, 0);
    chk("R1 target", target, 0);
    chk("R1 flag", {31'b0, event_flag}, 0);
    chk("R1 carry", {31'b0, carry_out}, 0);
    rst_n = 1;
    step();
    chk("R2 first count", counter, 1);
    chk("R4 match at 0", {31'b0, event_flag}, 1);

    // R8 carry holds, flag sticky with no consume
    repeat (5) step();
    chk("R8 carry hold", {31'b0, carry_out}, 0);
    chk("R4 sticky", {31'b0, event_flag}, 1);

    // R6 jump test consumes
    jtest_req = 1; step(); jtest_req = 0;
    chk("R6 carry", {31'b0, carry_out}, 1);
    chk("R6 cleared", {31'b0, event_flag}, 0);
    repeat (3) step();
    chk("R8 carry kept", {31'b0, carry_out}, 1);

    // R3 relative add, hold and modular wrap
    add_val = 32'd100; add_en = 1; step(); add_en = 0;
    chk("R3 add", target, 32'd100);
    repeat (2) step();
    chk("R3 hold", target, 32'd100);
    add_val = 32'hFFFF_FFF0; add_en = 1; step(); add_en = 0;
    chk("R3 wrap add", target, 32'd84);

    // R4 / R5 single match, then empty poll
    prev_flag = event_flag;
    for (int i = 0; i < 200; i++) begin
      prev_flag = event_flag;
      step();
      if (counter == target + 1) break;
    end
    chk("R4 was clear", {31'b0, prev_flag}, 0);
    chk("R4 set after match", {31'b0, event_flag}, 1);
    poll_req = 1; step(); poll_req = 0;
    chk("R5 poll carry", {31'b0, carry_out}, 1);
    chk("R5 poll cleared", {31'b0, event_flag}, 0);
    poll_req = 1; step(); poll_req = 0;
    chk("R5 empty poll", {31'b0, carry_out}, 0);

    // R7 consume in the very clock of the match
    c = counter;
    add_val = c + 8 - target; add_en = 1; step(); add_en = 0;
    for (int i = 0; i < 20; i++) begin
      if (counter == target) break;
      step();
    end
    poll_req = 1; step(); poll_req = 0;
    chk("R7 carry reads 0", {31'b0, carry_out}, 0);
    chk("R7 flag kept", {31'b0, event_flag}, 1);
    jtest_req = 1; step(); jtest_req = 0;
    chk("R7 next consume", {31'b0, carry_out}, 1);
    chk("R7 then clear", {31'b0, event_flag}, 0);

    // R9 phase sweep against a two-clock poll loop
    for (int ph = 0; ph < 8; ph++) begin
      c = counter;
      add_val = c + 20 + ph - target; add_en = 1; step(); add_en = 0;
      repeat (ph) step();
      hits = 0;
      for (int i = 0; i < 40; i++) begin
        if (ph[0]) jtest_req = 1; else poll_req = 1;
        step();
        poll_req = 0; jtest_req = 0;
        if (carry_out) hits++;
        step();
      end
      chk("R9 reported once", hits, 1);
      chk("R9 flag drained", {31'b0, event_flag}, 0);
    end

    // random mix with the model, rearming whenever the target is passed
    for (int i = 0; i < 4000; i++) begin
      add_en    = (target - counter) > 32'h8000_0000 || target == counter ? ($urandom % 3 == 0) : 1'b0;
      add_val   = 1 + $urandom % 12;
      poll_req  = ($urandom % 4 == 0);
      jtest_req = ($urandom % 6 == 0);
      step();
    end
    add_en = 0; poll_req = 0; jtest_req = 0;

    // R2 wrap on the narrow instance
    for (int i = 0; i < 300; i++) begin
      if (n_counter == 8'hFF) break;
      step();
    end
    step();
    chk("R2 wrap", {24'b0, n_counter}, 0);

    finish_run();
  end
endmodule